// File: doc/BRIEF.md
# Vector Atomic Memory Operation Decoder

This block looks at one 32-bit instruction word per cycle and decides, without any storage, whether it is a vector atomic read-modify-write instruction. Such instructions share the major opcode of the scalar atomics. They are told apart by a vector memory width code in the funct3 position. When the word matches, the block splits it into an operation code, a memory element size, the three register numbers and the two control bits. The two control bits are write-back-to-destination and unmasked.

The same block checks the match against the live vector configuration. That configuration is the element width code, the illegal-configuration flag, the atomics enable and the scalar register width. The result is exactly one of two flags: legal or illegal. Words that do not match raise neither flag, so a neighbouring decoder can claim them. The issue stage feeds the block directly and uses the descriptor in the same cycle.

Top module: `vamo_decoder`

## Requirements
- R1: `is_vamo_o` is 1 exactly when `valid_i` is 1, bits [6:0] equal 0101111, bits [14:12] equal 110 or 111, and bits [31:27] hold one of the nine operation patterns listed in R2. Any other word gives 0.
- R2: `op_o` encodes bits [31:27] as follows: 00001 swap=1, 00000 add=2, 00100 xor=3, 01100 and=4, 01000 or=5, 10000 signed min=6, 10100 signed max=7, 11000 unsigned min=8, 11100 unsigned max=9. The value is 0 when `is_vamo_o` is 0.
- R3: `mem_size_o` gives log2 of the memory element size in bytes: 2 for width code 110 (32 bits) and 3 for width code 111 (64 bits).
- R4: On a match, `vd_o`=bits [11:7], `rs1_o`=bits [19:15], `vs2_o`=bits [24:20], `wd_o`=bit 26 and `vm_o`=bit 25.
- R5: A match is illegal when `vill_i` is 1 or `amo_en_i` is 0.
- R6: `sew_i` codes 0..3 mean 8, 16, 32 and 64-bit elements. A match is illegal when the element width is below 32 or above XLEN. XLEN is 64 when `xlen64_i` is 1 and 32 when it is 0.
- R7: A match with width code 111 is illegal when `xlen64_i` is 0.
- R8: A match is illegal when the memory element is wider than the element width (width code 111 with `sew_i`=2).
- R9: A match with wd=1, vm=0 and vd=0 is illegal, because the destination would overlap the mask register.
- R10: `legal_o` and `illegal_o` are never both 1. Neither is 1 when `is_vamo_o` is 0, and one of them is 1 when it is 1.
- R11: When `valid_i` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Instruction word is present |
| instr_i | input | 32 | Instruction word |
| sew_i | input | 2 | Element width code (0..3 = 8..64 bits) |
| vill_i | input | 1 | Vector configuration is illegal |
| amo_en_i | input | 1 | Atomic instructions enabled |
| xlen64_i | input | 1 | Scalar width is 64 (else 32) |
| is_vamo_o | output | 1 | Word is a vector atomic |
| legal_o | output | 1 | Match and all legality rules pass |
| illegal_o | output | 1 | Match but some rule fails |
| op_o | output | 4 | Operation code (R2) |
| mem_size_o | output | 2 | log2 bytes of memory element |
| vd_o | output | 5 | Destination / source-data vector register |
| rs1_o | output | 5 | Scalar base register |
| vs2_o | output | 5 | Index vector register |
| wd_o | output | 1 | Write old value back to vd |
| vm_o | output | 1 | Unmasked (1) or masked by v0 (0) |

## Verification
The bench targets three areas: the non-operation funct5 patterns inside the vector width codes, the scalar width codes, and a near-miss opcode. A decoder that keyed only on opcode and width would raise a flag on any of these and steal them from other decoders. The bench sweeps every element width code against both scalar widths and both memory sizes. This exposes a decoder that omits the element-width-versus-memory-size rule or the XLEN limit, since it would report a 64-bit atomic as legal with 32-bit elements or on a 32-bit core. The mask overlap rule is exercised with vd at zero and non-zero for all four wd/vm pairs. A design that tested only one of the two bits would reject legal unmasked forms or accept the overlapping one.

// File: rtl/vamo_pkg.sv
package vamo_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned OP_W   = 4;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [2:0] WID_M32    = 3'b110;
  localparam logic [2:0] WID_M64    = 3'b111;

  typedef enum logic [OP_W-1:0] {
    VAMO_NONE = 4'd0,
    VAMO_SWAP = 4'd1,
    VAMO_ADD  = 4'd2,
    VAMO_XOR  = 4'd3,
    VAMO_AND  = 4'd4,
    VAMO_OR   = 4'd5,
    VAMO_MIN  = 4'd6,
    VAMO_MAX  = 4'd7,
    VAMO_MINU = 4'd8,
    VAMO_MAXU = 4'd9
  } vamo_op_e;

  typedef struct packed {
    logic [4:0]        funct5;
    logic              wd;
    logic              vm;
    logic [REG_AW-1:0] vs2;
    logic [REG_AW-1:0] rs1;
    logic [2:0]        width;
    logic [REG_AW-1:0] vd;
    logic [6:0]        opcode;
  } vamo_raw_t;
endpackage

// File: rtl/vamo_field_split.sv
module vamo_field_split
  import vamo_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output vamo_raw_t       raw_o,
  output logic            opc_hit_o,
  output logic            wid_hit_o,
  output logic            wid64_o
);
  assign raw_o     = vamo_raw_t'(instr_i);
  assign opc_hit_o = (raw_o.opcode == OPC_ATOMIC);
  assign wid_hit_o = (raw_o.width == WID_M32) || (raw_o.width == WID_M64);
  assign wid64_o   = (raw_o.width == WID_M64);
endmodule

// File: rtl/vamo_op_lookup.sv
module vamo_op_lookup
  import vamo_pkg::*;
(
  input  logic [4:0] funct5_i,
  output vamo_op_e   op_o,
  output logic       known_o
);
  always_comb begin
    unique case (funct5_i)
      5'b00001: op_o = VAMO_SWAP;
      5'b00000: op_o = VAMO_ADD;
      5'b00100: op_o = VAMO_XOR;
      5'b01100: op_o = VAMO_AND;
      5'b01000: op_o = VAMO_OR;
      5'b10000: op_o = VAMO_MIN;
      5'b10100: op_o = VAMO_MAX;
      5'b11000: op_o = VAMO_MINU;
      5'b11100: op_o = VAMO_MAXU;
      default:  op_o = VAMO_NONE;
    endcase
  end
  assign known_o = (op_o != VAMO_NONE);
endmodule

// File: rtl/vamo_legal_check.sv
module vamo_legal_check
  import vamo_pkg::*;
#(
  parameter int unsigned SEW_W        = 2,
  parameter int unsigned MIN_SEW_BITS = 32,
  parameter int unsigned XLEN_LO      = 32,
  parameter int unsigned XLEN_HI      = 64
) (
  input  logic [SEW_W-1:0]  sew_i,
  input  logic              vill_i,
  input  logic              amo_en_i,
  input  logic              xlen64_i,
  input  logic              wid64_i,
  input  logic              wd_i,
  input  logic              vm_i,
  input  logic [REG_AW-1:0] vd_i,
  output logic              bad_o
);
  localparam int unsigned SEW_CODES = 1 << SEW_W;
  localparam int unsigned MEM_LO    = 32;
  localparam int unsigned MEM_HI    = 64;

  // per-code legality masks, one per (XLEN, memory size) pairing
  logic [SEW_CODES-1:0] ok_x32_m32, ok_x64_m32, ok_x64_m64;

  for (genvar k = 0; k < SEW_CODES; k++) begin : g_sew
    localparam int unsigned SB = 8 << k;
    assign ok_x32_m32[k] = (SB >= MIN_SEW_BITS) && (SB <= XLEN_LO) && (SB >= MEM_LO);
    assign ok_x64_m32[k] = (SB >= MIN_SEW_BITS) && (SB <= XLEN_HI) && (SB >= MEM_LO);
    assign ok_x64_m64[k] = (SB >= MIN_SEW_BITS) && (SB <= XLEN_HI) && (SB >= MEM_HI);
  end

  logic cfg_bad, sew_ok, overlap;

  assign cfg_bad = vill_i || !amo_en_i;
  assign overlap = wd_i && !vm_i && (vd_i == '0);

  always_comb begin
    unique case ({xlen64_i, wid64_i})
      2'b00:   sew_ok = ok_x32_m32[sew_i];
      2'b10:   sew_ok = ok_x64_m32[sew_i];
      2'b11:   sew_ok = ok_x64_m64[sew_i];
      default: sew_ok = 1'b0; // 64-bit memory on a 32-bit core
    endcase
  end

  assign bad_o = cfg_bad || !sew_ok || overlap;
endmodule

// File: rtl/vamo_decoder.sv
module vamo_decoder
  import vamo_pkg::*;
#(
  parameter int unsigned SEW_W = 2
) (
  input  logic              valid_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic              vill_i,
  input  logic              amo_en_i,
  input  logic              xlen64_i,
  output logic              is_vamo_o,
  output logic              legal_o,
  output logic              illegal_o,
  output logic [OP_W-1:0]   op_o,
  output logic [1:0]        mem_size_o,
  output logic [REG_AW-1:0] vd_o,
  output logic [REG_AW-1:0] rs1_o,
  output logic [REG_AW-1:0] vs2_o,
  output logic              wd_o,
  output logic              vm_o
);
  vamo_raw_t raw;
  logic      opc_hit, wid_hit, wid64, known, bad, hit;
  vamo_op_e  op;

  vamo_field_split u_split (
    .instr_i   (instr_i),
    .raw_o     (raw),
    .opc_hit_o (opc_hit),
    .wid_hit_o (wid_hit),
    .wid64_o   (wid64)
  );

  vamo_op_lookup u_op (
    .funct5_i (raw.funct5),
    .op_o     (op),
    .known_o  (known)
  );

  vamo_legal_check #(.SEW_W(SEW_W)) u_chk (
    .sew_i    (sew_i),
    .vill_i   (vill_i),
    .amo_en_i (amo_en_i),
    .xlen64_i (xlen64_i),
    .wid64_i  (wid64),
    .wd_i     (raw.wd),
    .vm_i     (raw.vm),
    .vd_i     (raw.vd),
    .bad_o    (bad)
  );

  assign hit = valid_i && opc_hit && wid_hit && known;

  // descriptor is zeroed on a miss so downstream muxes see a clean bus
  always_comb begin
    is_vamo_o  = hit;
    legal_o    = hit && !bad;
    illegal_o  = hit && bad;
    op_o       = hit ? op : VAMO_NONE;
    mem_size_o = hit ? (wid64 ? 2'd3 : 2'd2) : 2'd0;
    vd_o       = hit ? raw.vd  : '0;
    rs1_o      = hit ? raw.rs1 : '0;
    vs2_o      = hit ? raw.vs2 : '0;
    wd_o       = hit && raw.wd;
    vm_o       = hit && raw.vm;
  end
endmodule

// File: rtl/vamo_decoder_chk.sv
module vamo_decoder_chk
  import vamo_pkg::*;
#(
  parameter int unsigned SEW_W = 2
) (
  input logic              valid_i,
  input logic [ILEN-1:0]   instr_i,
  input logic [SEW_W-1:0]  sew_i,
  input logic              vill_i,
  input logic              amo_en_i,
  input logic              xlen64_i,
  input logic              is_vamo_o,
  input logic              legal_o,
  input logic              illegal_o,
  input logic [OP_W-1:0]   op_o,
  input logic [1:0]        mem_size_o,
  input logic [REG_AW-1:0] vd_o,
  input logic [REG_AW-1:0] rs1_o,
  input logic [REG_AW-1:0] vs2_o,
  input logic              wd_o,
  input logic              vm_o
);
  always_comb begin
    AST_FLAG_EXCL: assert (!(legal_o && illegal_o)) else $error("both flags"); // R10
    AST_FLAG_COVER: assert ((legal_o || illegal_o) == is_vamo_o) else $error("flag/match mismatch"); // R10
    AST_IDLE_ZERO: assert (valid_i || !(is_vamo_o || legal_o || illegal_o || wd_o || vm_o
                                        || op_o != '0 || mem_size_o != '0 || vd_o != '0
                                        || rs1_o != '0 || vs2_o != '0))
      else $error("output while idle"); // R11
    AST_MATCH_OPC: assert (!is_vamo_o || (instr_i[6:0] == OPC_ATOMIC && instr_i[14:13] == 2'b11))
      else $error("bad match"); // R1
    AST_OP_RANGE: assert (is_vamo_o == (op_o != '0) && op_o <= 4'd9) else $error("op range"); // R2
    AST_CFG_GATE: assert (!legal_o || (!vill_i && amo_en_i)) else $error("cfg gate"); // R5
    AST_SEW_FLOOR: assert (!legal_o || sew_i >= 2'd2) else $error("sew floor"); // R6
    AST_XLEN_MEM: assert (!legal_o || xlen64_i || mem_size_o == 2'd2) else $error("xlen mem"); // R7
    AST_MASK_OVERLAP: assert (!legal_o || vm_o || !wd_o || vd_o != '0) else $error("overlap"); // R9
    AST_FIELD_VD: assert (!is_vamo_o || vd_o == instr_i[11:7]) else $error("vd field"); // R4
  end
endmodule

bind vamo_decoder vamo_decoder_chk #(.SEW_W(SEW_W)) u_vamo_chk (.*);

// File: tb/tb_vamo_decoder.sv
module tb_vamo_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic        valid;
  logic [31:0] instr;
  logic [1:0]  sew;
  logic        vill, amo_en, x64;
  logic        is_vamo, legal, illegal, wd, vm;
  logic [3:0]  op;
  logic [1:0]  msz;
  logic [4:0]  vd, rs1, vs2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  vamo_decoder dut (
    .valid_i(valid), .instr_i(instr), .sew_i(sew), .vill_i(vill),
    .amo_en_i(amo_en), .xlen64_i(x64), .is_vamo_o(is_vamo), .legal_o(legal),
    .illegal_o(illegal), .op_o(op), .mem_size_o(msz), .vd_o(vd), .rs1_o(rs1),
    .vs2_o(vs2), .wd_o(wd), .vm_o(vm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s instr=%h sew=%0d vill=%0b en=%0b x64=%0b act=%0d exp=%0d",
               tag, instr, sew, vill, amo_en, x64, act, exp);
    end
  endtask

  function automatic int op_code(input logic [4:0] f);
    case (f)
      5'b00001: return 1;
      5'b00000: return 2;
      5'b00100: return 3;
      5'b01100: return 4;
      5'b01000: return 5;
      5'b10000: return 6;
      5'b10100: return 7;
      5'b11000: return 8;
      5'b11100: return 9;
      default:  return 0;
    endcase
  endfunction

  task automatic check_all();
    int   code, sew_bits, xlen, mem_bits;
    bit   hit, ill;
    code     = op_code(instr[31:27]);
    hit      = valid && instr[6:0] == 7'b0101111 && instr[14:13] == 2'b11 && code != 0;
    sew_bits = 8 << sew;
    xlen     = x64 ? 64 : 32;
    mem_bits = instr[12] ? 64 : 32;
    ill = vill || !amo_en                                        // R5
          || sew_bits < 32 || sew_bits > xlen                    // R6
          || mem_bits > xlen                                     // R7
          || mem_bits > sew_bits                                 // R8
          || (instr[26] && !instr[25] && instr[11:7] == 5'd0);   // R9
    chk("R1 is_vamo", int'(is_vamo), int'(hit));
    chk("R2 op", int'(op), hit ? code : 0);
    chk("R3 mem_size", int'(msz), hit ? (mem_bits == 64 ? 3 : 2) : 0);
    chk("R4 vd", int'(vd), hit ? int'(instr[11:7]) : 0);
    chk("R4 rs1", int'(rs1), hit ? int'(instr[19:15]) : 0);
    chk("R4 vs2", int'(vs2), hit ? int'(instr[24:20]) : 0);
    chk("R4 wd/vm", int'({wd, vm}), hit ? int'(instr[26:25]) : 0);
    chk("R10 legal", int'(legal), int'(hit && !ill));
    chk("R10 illegal", int'(illegal), int'(hit && ill));
    if (!valid)
      chk("R11 idle", int'({is_vamo, legal, illegal, op, msz, vd, rs1, vs2, wd, vm}), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    valid = 0; instr = 32'h0000_672F; sew = 2; vill = 0; amo_en = 1; x64 = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(); // reset/idle state, R11
    rst_n = 1'b1;
    valid = 1;
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int f5 = 0; f5 < 32; f5++) begin
        for (int ws = 0; ws < 4; ws++) begin
          for (int wm = 0; wm < 4; wm++) begin
            for (int vs = 0; vs < 2; vs++) begin
              logic [2:0] w;
              logic [6:0] opc;
              logic [4:0] dreg;
              @(posedge clk);
              sew    = cfg[1:0];
              vill   = cfg[2];
              amo_en = cfg[3];
              x64    = cfg[4];
              w      = (ws == 1) ? 3'b111 : (ws == 2) ? 3'b010 : 3'b110;
              opc    = (ws == 3) ? 7'b0100111 : 7'b0101111;
              dreg   = vs ? 5'((f5 % 31) + 1) : 5'd0;
              instr  = {5'(f5), 2'(wm), 5'(cfg + ws), 5'(f5 * 3 + wm), w, dreg, opc};
              @(negedge clk);
              check_all();
            end
          end
        end
      end
    end
    // R11: valid low with matching words under every configuration
    valid = 0;
    for (int cfg = 0; cfg < 32; cfg++) begin
      @(posedge clk);
      sew = cfg[1:0]; vill = cfg[2]; amo_en = cfg[3]; x64 = cfg[4];
      instr = {5'b11100, 2'b11, 5'd9, 5'd4, 3'b111, 5'(cfg), 7'b0101111};
      @(negedge clk);
      check_all();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule